// File: doc/BRIEF.md
# Ones' Complement Compare-Skip and Overflow Unit

This block is the arithmetic core behind two accumulator instructions of a ones'-complement processor. The first, a count-compare-skip, takes a memory operand, classifies it as positive, plus zero, negative or minus zero, and replaces the accumulator with its diminished absolute value. It also returns how many instructions the sequencer must skip. The second, a store-with-overflow, inspects the two top bits of the accumulator. It produces a corrected word for memory, and when the accumulator has overflowed it turns the accumulator into a +1 or -1 carry for the next word of a multi-precision sum.

The surrounding sequencer supplies the opcode select, the memory operand and the current accumulator value with a one-cycle start strobe. One clock later the block presents the new accumulator, the store word with a write pulse, the skip count and a done pulse. All results hold their values until the next start. Fetch, memory and the program counter stay outside the block.

Top module: `ocsu_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `acc_q`, `store_q`, `skip_q`, `wr_q` and `done_q` all become zero.
- R2: `op`=0 selects compare-skip and `op`=1 selects store. `done_q` is high exactly in the cycle after a cycle with `start` high. Without a start, every output register keeps its value.
- R3: Compare-skip with a positive operand (bit 15 clear, not all zeros) gives `acc_q` = operand - 1 and `skip_q` = 0.
- R4: Compare-skip with plus zero (all bits clear) gives `acc_q` = 0 and `skip_q` = 1.
- R5: Compare-skip with a negative operand (bit 15 set, not all ones) gives `acc_q` = (bitwise inverse of operand) - 1 and `skip_q` = 2.
- R6: Compare-skip with minus zero (all bits set) gives `acc_q` = 0 and `skip_q` = 3.
- R7: Compare-skip does not write. `wr_q` stays low, `store_q` keeps its previous value, and `acc_in` has no effect on the result.
- R8: A store whose accumulator has bits 15 and 14 equal pulses `wr_q`, sets `store_q` = `acc_in` and `acc_q` = `acc_in`, and gives `skip_q` = 0. `operand` has no effect on a store.
- R9: A store whose accumulator has bit 15 clear and bit 14 set (positive overflow) sets `store_q` to bits 15 and 14 clear over the accumulator's bits 13:0, `acc_q` = 16'h0001, and `skip_q` = 1.
- R10: A store whose accumulator has bit 15 set and bit 14 clear (negative overflow) sets `store_q` to bits 15 and 14 set over bits 13:0, `acc_q` = 16'hFFFE (minus one), and `skip_q` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe, one cycle per operation |
| op | input | 1 | 0 = compare-skip, 1 = store with overflow correction |
| operand | input | 16 | Memory operand for compare-skip |
| acc_in | input | 16 | Current accumulator for store |
| acc_q | output | 16 | New accumulator value |
| store_q | output | 16 | Word to write to memory |
| skip_q | output | 2 | Number of instructions to skip |
| wr_q | output | 1 | Store word valid, one-cycle pulse |
| done_q | output | 1 | Result valid, one-cycle pulse |

## Verification
The bench targets the two zeros. A design that tests only for all-zero bits would send minus zero down the negative path, with skip 2 and a wrapped result. The neighbours of each zero are also covered: the most negative value 16'h8000 and minus one 16'hFFFE, where an off-by-one in the complement-then-decrement path appears. On the store side, all four top-bit patterns are driven. A swapped overflow polarity gives the wrong carry sign. A design that keeps bit 14 instead of copying the sign into it writes a word that is still overflowed. Random operations run between these cases and confirm that the store word and the write pulse survive compare-skip operations unchanged.

// File: rtl/ocsu_pkg.sv
// Shared definitions for the compare-skip / overflow unit.
// Assumes a one-bit opcode select supplied by the sequencer.
package ocsu_pkg;
    typedef enum logic {
        OP_CCS = 1'b0,
        OP_TS  = 1'b1
    } ocsu_op_e;

    localparam int SKIP_W = 2;
    localparam logic [SKIP_W-1:0] SKIP_POS   = 2'd0;
    localparam logic [SKIP_W-1:0] SKIP_PZERO = 2'd1;
    localparam logic [SKIP_W-1:0] SKIP_NEG   = 2'd2;
    localparam logic [SKIP_W-1:0] SKIP_MZERO = 2'd3;
endpackage

// File: rtl/ocsu_dabs.sv
// Combinational compare-skip datapath: classifies a ones'-complement word
// and forms its diminished absolute value (magnitude minus one, floored at
// plus zero). Assumes bit W-1 is the sign; all-ones is minus zero.
module ocsu_dabs
    import ocsu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]      value_i,
    output logic [W-1:0]      dabs_o,
    output logic [SKIP_W-1:0] skip_o
);
    logic          is_pzero;
    logic          is_mzero;
    logic [W-1:0]  magnitude;

    // Purpose: detect both zero encodings and fold negatives to a magnitude.
    always_comb begin
        is_pzero  = (value_i == '0);
        is_mzero  = (value_i == '1);
        magnitude = value_i[W-1] ? ~value_i : value_i;
    end

    // Purpose: decrement the magnitude without going below plus zero.
    always_comb begin
        if (magnitude == '0) dabs_o = '0;
        else                 dabs_o = magnitude - {{(W-1){1'b0}}, 1'b1};
    end

    // Purpose: pick the four-way skip from the class of the original value.
    always_comb begin
        if (is_pzero)          skip_o = SKIP_PZERO;
        else if (is_mzero)     skip_o = SKIP_MZERO;
        else if (value_i[W-1]) skip_o = SKIP_NEG;
        else                   skip_o = SKIP_POS;
    end
endmodule

// File: rtl/ocsu_ovf.sv
// Combinational store-with-overflow datapath. The two top bits of the
// accumulator disagree on overflow; the top bit is then the true sign.
// Assumes W >= 3 so a magnitude field sits below the two top bits.
module ocsu_ovf
    import ocsu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]      acc_i,
    output logic [W-1:0]      store_o,
    output logic [W-1:0]      acc_o,
    output logic [SKIP_W-1:0] skip_o
);
    localparam int MAG_W = W - 2;
    localparam logic [W-1:0] PLUS_ONE = {{(W-1){1'b0}}, 1'b1};

    logic overflow;
    logic sign;

    // Purpose: flag overflow and take the leftmost bit as the corrected sign.
    always_comb begin
        overflow = acc_i[W-1] ^ acc_i[W-2];
        sign     = acc_i[W-1];
    end

    // Purpose: build the store word, the carry accumulator and the skip.
    always_comb begin
        if (overflow) begin
            store_o = {sign, sign, acc_i[MAG_W-1:0]};
            acc_o   = sign ? ~PLUS_ONE : PLUS_ONE;
            skip_o  = SKIP_PZERO;
        end else begin
            store_o = acc_i;
            acc_o   = acc_i;
            skip_o  = SKIP_POS;
        end
    end
endmodule

// File: rtl/ocsu_top.sv
// Compare-skip and overflow unit top. Registers the selected datapath result
// one cycle after start and pulses done. The store word is only updated by a
// store operation; compare-skip leaves it and never pulses the write.
// Assumes start is a single-cycle strobe from the sequencer.
module ocsu_top
    import ocsu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op,
    input  logic [W-1:0]      operand,
    input  logic [W-1:0]      acc_in,
    output logic [W-1:0]      acc_q,
    output logic [W-1:0]      store_q,
    output logic [SKIP_W-1:0] skip_q,
    output logic              wr_q,
    output logic              done_q
);
    localparam logic [W-1:0] UNIT = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0]      c_dabs;
    logic [SKIP_W-1:0] c_skip;
    logic [W-1:0]      t_store;
    logic [W-1:0]      t_acc;
    logic [SKIP_W-1:0] t_skip;
    ocsu_op_e          op_sel;
    ocsu_op_e          op_q;

    assign op_sel = ocsu_op_e'(op);

    ocsu_dabs #(.W(W)) u_dabs (
        .value_i (operand),
        .dabs_o  (c_dabs),
        .skip_o  (c_skip)
    );

    ocsu_ovf #(.W(W)) u_ovf (
        .acc_i   (acc_in),
        .store_o (t_store),
        .acc_o   (t_acc),
        .skip_o  (t_skip)
    );

    // Purpose: register the chosen result and the one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            store_q <= '0;
            skip_q  <= '0;
            wr_q    <= 1'b0;
            done_q  <= 1'b0;
            op_q    <= OP_CCS;
        end else begin
            done_q <= start;
            wr_q   <= start && (op_sel == OP_TS);
            if (start) begin
                op_q <= op_sel;
                if (op_sel == OP_TS) begin
                    acc_q   <= t_acc;
                    store_q <= t_store;
                    skip_q  <= t_skip;
                end else begin
                    acc_q  <= c_dabs;
                    skip_q <= c_skip;
                end
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done_q); // R2
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done_q); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> ($stable(acc_q) && $stable(store_q) && $stable(skip_q))); // R2
    AST_CCS_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && op_q == OP_CCS) |-> !acc_q[W-1]); // R3
    AST_CCS_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && op_q == OP_CCS && skip_q[0]) |-> (acc_q == '0)); // R4 R6
    AST_CCS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && op_q == OP_CCS) |-> !wr_q); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && op_q == OP_TS) |-> (store_q[W-1] == store_q[W-2])); // R9
    AST_TS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && op_q == OP_TS && skip_q == SKIP_PZERO)
            |-> (acc_q == UNIT || acc_q == ~UNIT)); // R10
endmodule

// File: tb/ocsu_top_tb_top.sv
module ocsu_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op = 1'b0;
    logic [15:0] operand = '0;
    logic [15:0] acc_in = '0;
    logic [15:0] acc_q;
    logic [15:0] store_q;
    logic [1:0]  skip_q;
    logic        wr_q;
    logic        done_q;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [15:0] e_acc = '0;
    logic [15:0] e_store = '0;
    logic [1:0]  e_skip = '0;

    always #2.5 clk = ~clk;

    ocsu_top dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .operand(operand), .acc_in(acc_in),
        .acc_q(acc_q), .store_q(store_q), .skip_q(skip_q),
        .wr_q(wr_q), .done_q(done_q)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_dabs(input logic [15:0] x);
        if (x == 16'h0000 || x == 16'hFFFF) return 16'h0000;
        if (!x[15]) return x - 16'd1;
        return (16'hFFFF - x) - 16'd1;
    endfunction

    function automatic logic [1:0] ref_ccs_skip(input logic [15:0] x);
        if (x == 16'h0000) return 2'd1;
        if (x == 16'hFFFF) return 2'd3;
        return x[15] ? 2'd2 : 2'd0;
    endfunction

    // One operation: strobe at a falling edge, sample at the next falling edge.
    task automatic run(input logic o, input logic [15:0] opnd, input logic [15:0] a);
        string rq;
        @(negedge clk);
        start = 1'b1; op = o; operand = opnd; acc_in = a;
        @(negedge clk);
        start = 1'b0;
        operand = 16'hDEAD; acc_in = 16'hBEEF;
        if (!o) begin
            e_acc  = ref_dabs(opnd);
            e_skip = ref_ccs_skip(opnd);
            case (e_skip)
                2'd0: rq = "R3";
                2'd1: rq = "R4";
                2'd2: rq = "R5";
                default: rq = "R6";
            endcase
            chk(rq, acc_q, e_acc);
            chk(rq, {14'd0, skip_q}, {14'd0, e_skip});
            chk("R7", {15'd0, wr_q}, 16'd0);
            chk("R7", store_q, e_store);
        end else begin
            case (a[15:14])
                2'b01: begin
                    rq = "R9"; e_store = {2'b00, a[13:0]};
                    e_acc = 16'h0001; e_skip = 2'd1;
                end
                2'b10: begin
                    rq = "R10"; e_store = {2'b11, a[13:0]};
                    e_acc = 16'hFFFE; e_skip = 2'd1;
                end
                default: begin
                    rq = "R8"; e_store = a; e_acc = a; e_skip = 2'd0;
                end
            endcase
            chk(rq, acc_q, e_acc);
            chk(rq, store_q, e_store);
            chk(rq, {14'd0, skip_q}, {14'd0, e_skip});
            chk(rq, {15'd0, wr_q}, 16'd1);
        end
        chk("R2", {15'd0, done_q}, 16'd1);
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        chk("R1", acc_q, 16'h0000);
        chk("R1", store_q, 16'h0000);
        chk("R1", {14'd0, skip_q}, 16'd0);
        chk("R1", {15'd0, wr_q}, 16'd0);
        chk("R1", {15'd0, done_q}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2", {15'd0, done_q}, 16'd0);

        run(1'b0, 16'h0001, 16'h1111);
        run(1'b0, 16'h7FFF, 16'h2222);
        run(1'b0, 16'h0000, 16'hFFFF);
        run(1'b0, 16'hFFFF, 16'h0000);
        run(1'b0, 16'hFFFE, 16'h4000);
        run(1'b0, 16'h8000, 16'h8000);
        run(1'b1, 16'h0000, 16'h1234);
        run(1'b1, 16'hFFFF, 16'hC000);
        run(1'b1, 16'h0000, 16'h4005);
        run(1'b1, 16'h0000, 16'h7FFF);
        run(1'b1, 16'h0000, 16'h8003);
        run(1'b1, 16'h0000, 16'hBFFF);
        run(1'b0, 16'h0005, 16'h7000);
        // idle cycles: outputs hold, no pulses
        repeat (3) @(negedge clk);
        chk("R2", acc_q, e_acc);
        chk("R2", store_q, e_store);
        chk("R2", {14'd0, skip_q}, {14'd0, e_skip});
        chk("R2", {15'd0, done_q}, 16'd0);
        chk("R7", {15'd0, wr_q}, 16'd0);

        for (int i = 0; i < 400; i++) begin
            logic [15:0] v;
            logic [15:0] w;
            int cls;
            cls = $urandom_range(0, 5);
            v = 16'($urandom);
            w = 16'($urandom);
            if (cls == 0) v = 16'h0000;
            if (cls == 1) v = 16'hFFFF;
            if (cls == 2) w = {2'b01, w[13:0]};
            if (cls == 3) w = {2'b10, w[13:0]};
            run(1'($urandom_range(0, 1)), v, w);
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end

        // mid-operation reset returns everything to zero
        run(1'b1, 16'h0000, 16'h4001);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", acc_q, 16'h0000);
        chk("R1", store_q, 16'h0000);
        chk("R1", {15'd0, wr_q}, 16'd0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule